// File: doc/BRIEF.md
# Input Capture Timer with Reload-on-Capture

This block pairs a free-running up-counter with a single input-capture channel. The counter steps once per clock. It runs from a programmable start value up to a programmable limit, then returns to the start value. When the capture strobe is high in a cycle, the counter value of that cycle is stored in a capture register and a sticky capture flag is raised. The flag drives an interrupt request when interrupts are enabled.

An optional reload-on-capture mode also returns the counter to the start value at each capture. The stored value then measures the time since the previous capture directly, with no subtraction. When the mode is off, captures do not disturb the counter. The strobe is expected to arrive already synchronized and filtered. The asynchronous reset is released through a short synchronizer inside the block.

Top module: `cap_timer`

## Requirements
- R1: While reset is held, and on the first clock after reset is released, the captured value is 0, the flag is 0 and the interrupt request is 0. The counter holds 0 until two clock edges after `rst_n` rises, so a capture in the cycle after those two edges stores 0.
- R2: When no reload occurs, the counter increases by one on each clock edge while its value is below `mod_val`. At an edge where its value is greater than or equal to `mod_val`, it loads `init_val`.
- R3: When `cap_evt` is 1 during a cycle, `cap_val` shows the counter value of that cycle after the next clock edge.
- R4: Every capture sets `cap_flag`. The flag stays 1 until a cycle with `flag_clr` = 1 and no capture, after which it reads 0.
- R5: If `cap_evt` and `flag_clr` are both 1 in the same cycle, the flag is 1 afterwards.
- R6: `irq` equals `cap_flag` AND `irq_en`, with no clock delay. Changing `irq_en` does not alter `cap_flag`.
- R7: With `rst_on_cap` = 1, a capture loads `init_val` into the counter at the same edge that stores the capture. If two captures are d cycles apart and no wrap occurs between them, the second stored value is `init_val` + d − 1. With `init_val` = 1, it equals d.
- R8: With `rst_on_cap` = 0, captures leave the counter sequence of R2 unchanged.
- R9: In a cycle without `cap_evt`, `cap_val` keeps its value across the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_evt | input | 1 | Capture strobe, one cycle per event |
| init_val | input | 16 | Counter start and reload value |
| mod_val | input | 16 | Counter upper limit |
| rst_on_cap | input | 1 | 1: reload the counter on each capture |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the capture flag (a capture in the same cycle takes priority) |
| cap_val | output | 16 | Last captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| irq | output | 1 | Interrupt request |

## Verification
A capture strobe held during one cycle shows up in `cap_val` and `cap_flag` one clock edge later. A reload selected by that capture appears as the counter value of the next cycle, so it can be observed only through the following capture. The interrupt request follows `irq_en` with no clock delay. The bench drives the inputs at the falling edge and lets exactly one rising edge pass. It then checks the registered outputs at the next falling edge against a cycle model that it updates once per rising edge. The `irq` check is made 1 ns after `irq_en` changes. After reset release, the bench counts the two synchronizer edges before it starts the counter model at 0.

// File: rtl/cap_pkg.sv
package cap_pkg;
  // source of the counter's next value
  typedef enum logic [1:0] {
    NXT_INC  = 2'd0,
    NXT_WRAP = 2'd1,
    NXT_CAP  = 2'd2
  } cnt_sel_e;
endpackage

// File: rtl/cap_rst_sync.sv
module cap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cap_counter.sv
module cap_counter
  import cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] init_val,
  input  logic [CNT_W-1:0] mod_val,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cnt_sel_e         sel;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (reload)              sel = NXT_CAP;
    else if (cnt >= mod_val) sel = NXT_WRAP;
    else                     sel = NXT_INC;
  end

  always_comb begin
    unique case (sel)
      NXT_CAP:  cnt_d = init_val;
      NXT_WRAP: cnt_d = init_val;
      NXT_INC:  cnt_d = cnt + ONE;
      default:  cnt_d = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && cnt < mod_val) |=> cnt == $past(cnt) + ONE); // R2
  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && cnt >= mod_val) |=> cnt == $past(init_val)); // R2
  AST_RELOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt == $past(init_val)); // R7
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic             flag_clr,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             irq
);
  logic             val_en;
  logic [CNT_W-1:0] val_d;
  logic             flag_en;
  logic             flag_d;

  always_comb begin
    val_en  = cap_evt;
    val_d   = cnt;
    flag_en = cap_evt | flag_clr;
    flag_d  = cap_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_val <= '0;
    else if (val_en) cap_val <= val_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_flag <= 1'b0;
    else if (flag_en) cap_flag <= flag_d;
  end

  assign irq = cap_flag & irq_en;

  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_val == $past(cnt)); // R3
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_evt) |=> !cap_flag); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clr && !cap_evt) |=> $stable(cap_flag)); // R4
  AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val)); // R9
endmodule

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic [CNT_W-1:0] init_val,
  input  logic [CNT_W-1:0] mod_val,
  input  logic             rst_on_cap,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             irq
);
  logic             rst_int_n;
  logic             reload;
  logic [CNT_W-1:0] cnt;

  cap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign reload = cap_evt & rst_on_cap;

  cap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .init_val (init_val),
    .mod_val  (mod_val),
    .reload   (reload),
    .cnt      (cnt)
  );

  cap_channel #(.CNT_W(CNT_W)) u_ch (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_evt  (cap_evt),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .cnt      (cnt),
    .cap_val  (cap_val),
    .cap_flag (cap_flag),
    .irq      (irq)
  );

  AST_NO_CAP_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!rst_on_cap && !cap_evt && cnt < mod_val) |=> cnt != $past(init_val) || $past(init_val) == $past(cnt) + CNT_W'(1)); // R8
endmodule

// File: tb/tb_cap_timer.sv
module tb_cap_timer;
  logic        clk;
  logic        rst_n;
  logic        cap_evt;
  logic [15:0] init_val;
  logic [15:0] mod_val;
  logic        rst_on_cap;
  logic        irq_en;
  logic        flag_clr;
  logic [15:0] cap_val;
  logic        cap_flag;
  logic        irq;

  int n_chk;
  int n_fail;

  logic [15:0] m_cnt;
  logic [15:0] m_cap;
  logic        m_flag;

  cap_timer dut (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .init_val(init_val),
    .mod_val(mod_val), .rst_on_cap(rst_on_cap), .irq_en(irq_en),
    .flag_clr(flag_clr), .cap_val(cap_val), .cap_flag(cap_flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cap_evt = 1'b0; flag_clr = 1'b0;
    @(negedge clk);
    check("R1", "cap_val in reset", 32'(cap_val), 0);
    check("R1", "flag in reset", 32'(cap_flag), 0);
    check("R1", "irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R1", "flag after release", 32'(cap_flag), 0);
    m_cnt = '0; m_cap = '0; m_flag = 1'b0;
  endtask

  // one clock: drive at negedge, update model at posedge, check at next negedge
  task automatic tick(input logic evt, input logic clr, input string req_cap);
    cap_evt = evt; flag_clr = clr;
    @(posedge clk);
    if (evt) begin
      m_cap = m_cnt; m_flag = 1'b1;
    end else if (clr) begin
      m_flag = 1'b0;
    end
    if (evt && rst_on_cap)    m_cnt = init_val;
    else if (m_cnt >= mod_val) m_cnt = init_val;
    else                       m_cnt = m_cnt + 16'd1;
    @(negedge clk);
    cap_evt = 1'b0; flag_clr = 1'b0;
    check(evt ? req_cap : "R9", "cap_val", 32'(cap_val), 32'(m_cap));
    check(evt && clr ? "R5" : "R4", "cap_flag", 32'(cap_flag), 32'(m_flag));
    check("R6", "irq", 32'(irq), 32'(m_flag & irq_en));
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cap_evt = 1'b0; flag_clr = 1'b0;
    init_val = 16'd2; mod_val = 16'd9; rst_on_cap = 1'b0; irq_en = 1'b0;

    // sweep: reload mode x irq enable x capture spacing 1..12
    for (int roc = 0; roc < 2; roc++) begin
      for (int en = 0; en < 2; en++) begin
        rst_on_cap = roc[0]; irq_en = en[0];
        do_reset();
        tick(1'b1, 1'b0, "R1");                    // first count after reset is 0
        for (int d = 1; d <= 12; d++) begin
          for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < d - 1; i++) tick(1'b0, 1'b0, "R2");
            tick(1'b1, 1'b0, roc ? "R7" : "R8");   // R2/R3 covered by the model
          end
          tick(1'b0, 1'b1, "R4");                  // clear
          tick(1'b0, 1'b0, "R4");
          tick(1'b1, 1'b1, "R5");                  // capture beats clear
        end
      end
    end

    // R7 arithmetic: init 1, wide limit, captured value equals spacing
    rst_on_cap = 1'b1; init_val = 16'd1; mod_val = 16'd1000; irq_en = 1'b1;
    do_reset();
    tick(1'b1, 1'b0, "R7");
    for (int d = 1; d <= 40; d++) begin
      for (int i = 0; i < d - 1; i++) tick(1'b0, 1'b0, "R9");
      tick(1'b1, 1'b0, "R7");
      check("R7", "period direct", 32'(cap_val), 32'(d));
    end

    // R8 arithmetic: free run, capture at fixed absolute cycles
    rst_on_cap = 1'b0; init_val = 16'd0; mod_val = 16'hFFFF;
    do_reset();
    for (int c = 0; c < 50; c++) begin
      tick((c % 7) == 3, 1'b0, "R8");
      if ((c % 7) == 3) check("R8", "free-run count", 32'(cap_val), 32'(c));
    end

    // R6: irq follows enable combinationally, flag untouched
    tick(1'b1, 1'b0, "R3");
    irq_en = 1'b0; #1;
    check("R6", "irq off", 32'(irq), 0);
    check("R6", "flag kept", 32'(cap_flag), 1);
    irq_en = 1'b1; #1;
    check("R6", "irq on", 32'(irq), 1);
    tick(1'b0, 1'b1, "R4");
    irq_en = 1'b1; #1;
    check("R6", "irq after clear", 32'(irq), 0);

    finish_run();
  end
endmodule